// File: doc/BRIEF.md
# Programmable Waveform Bus-Master Engine

This block drives an external parallel bus from a small table of waveform vectors that a host loads through a plain write port. Each vector fixes the levels of six control lines for one clock. It also names a test on the six ready inputs, and gives the vector to go to when that test is true and the vector to go to when it is false. A vector that waits on a signal simply names itself as its false successor. A vector may also request a FIFO advance and/or an address increment, which take effect only when it is left on its true path.

A run of vectors starting at entry 0 and ending at a vector marked last forms one transaction. When a run is started, a 32-bit transaction count is loaded. Each completed transaction decrements it, and the waveform restarts from entry 0 until the count is used up. A done pulse then marks the end. FIFO advances are throttled by the FIFO's flag for the direction chosen at start, so the engine waits instead of reading an empty FIFO or writing a full one.

The engine has three states. S_IDLE holds the control lines low and accepts table writes. Start with a nonzero count moves it to S_RUN; start with a zero count moves it straight to S_FINISH. S_RUN steps through the vectors and moves to S_FINISH when the last vector of the final transaction is taken. S_FINISH raises done for one clock and always returns to S_IDLE.

Top module: `wm_engine`

## Requirements
- R1: After reset, busy, done, fifo_rd and fifo_wr are 0, ctl_out is 0 and addr_out is 0.
- R2: In S_IDLE, cfg_we writes cfg_word into entry cfg_idx. The word layout is: [5:0] control levels, [8:6] select A, [11:9] select B, [13:12] condition operator, [16:14] true successor, [19:17] false successor, [20] last, [21] FIFO advance, [22] address increment. A write while busy changes nothing.
- R3: start in S_IDLE with a nonzero count_in latches count_in, addr_in and start_dir. On the next clock the engine is in S_RUN at entry 0 with busy high.
- R4: In S_RUN, ctl_out equals the control field of the current vector in every cycle. In S_IDLE and S_FINISH, ctl_out is 0.
- R5: The ready condition uses operator code 0 for input A alone, 1 for A AND B, 2 for A OR B and 3 for A XOR B. A and B are rdy_in bits picked by the selects, and select values 6 and 7 read as 0.
- R6: An unstalled vector moves on the next clock to its true successor when the condition holds, and to its false successor otherwise. No side action happens on the false path.
- R7: When a vector with FIFO advance is taken on its true path, fifo_rd pulses in that cycle if start_dir was 0, and fifo_wr pulses if start_dir was 1. Address increment adds 1 to addr_out on the next clock, wrapping at 9 bits.
- R8: A vector with FIFO advance stalls while fifo_empty (direction 0) or fifo_full (direction 1) is high. During the stall it keeps its entry, gives no strobe and leaves the address unchanged.
- R9: Taking the last vector decrements the count. If transactions remain, the engine goes to entry 0. Otherwise done is high for exactly the next clock with busy low, and the engine then returns to S_IDLE.
- R10: start with count_in equal to 0 gives a done pulse on the next clock and runs no vector.
- R11: start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Table write enable |
| cfg_idx | input | 3 | Table entry to write |
| cfg_word | input | 23 | Vector word |
| start | input | 1 | Begin a run |
| start_dir | input | 1 | 0: FIFO to bus, 1: bus to FIFO |
| count_in | input | 32 | Transaction count |
| addr_in | input | 9 | Starting address |
| rdy_in | input | 6 | Ready inputs |
| fifo_full | input | 1 | FIFO full flag |
| fifo_empty | input | 1 | FIFO empty flag |
| ctl_out | output | 6 | Control lines |
| addr_out | output | 9 | Bus address |
| fifo_rd | output | 1 | FIFO pop strobe |
| fifo_wr | output | 1 | FIFO push strobe |
| busy | output | 1 | Engine is running |
| done | output | 1 | One-clock completion pulse |

## Verification
The checker watches every cycle for several properties. The two strobes never rise together and never rise against a blocking FIFO flag. Strobes occur only while busy. Done is a single-clock pulse with busy low. The control lines are low whenever the engine is not running. The address holds while the engine is idle. The bench scenarios cover the rest: branch selection under each condition operator, wait loops, the ignored start and the ignored table write, address wrap, and whether the number of strobes and the final address match the transaction count when the FIFO flags toggle at random.

// File: rtl/wm_pkg.sv
package wm_pkg;
    localparam int NCTL  = 6;
    localparam int NRDY  = 6;
    localparam int NVEC  = 8;
    localparam int VIW   = $clog2(NVEC);
    localparam int RSW   = 3;

    typedef enum logic [1:0] {
        OP_A   = 2'd0,
        OP_AND = 2'd1,
        OP_OR  = 2'd2,
        OP_XOR = 2'd3
    } cond_op_e;

    typedef struct packed {
        logic            inc_addr;
        logic            adv_fifo;
        logic            last;
        logic [VIW-1:0]  nxt_f;
        logic [VIW-1:0]  nxt_t;
        cond_op_e        op;
        logic [RSW-1:0]  sel_b;
        logic [RSW-1:0]  sel_a;
        logic [NCTL-1:0] ctl;
    } wvec_t;

    localparam int VEC_W = $bits(wvec_t);

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_RUN    = 2'd1,
        S_FINISH = 2'd2
    } wm_state_e;
endpackage

// File: rtl/wm_vec_table.sv
module wm_vec_table import wm_pkg::*; #(
    parameter int NV = NVEC
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [$clog2(NV)-1:0] wr_idx,
    input  wvec_t                 wr_data,
    input  logic [$clog2(NV)-1:0] rd_idx,
    output wvec_t                 rd_data
);
    logic [NV-1:0][VEC_W-1:0] flat;

    for (genvar g = 0; g < NV; g++) begin : gen_ent
        wvec_t q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= '0;
            else if (wr_en && (wr_idx == g[$clog2(NV)-1:0]))
                q <= wr_data;
        end
        assign flat[g] = q;
    end

    assign rd_data = wvec_t'(flat[rd_idx]);
endmodule

// File: rtl/wm_cond.sv
module wm_cond import wm_pkg::*; (
    input  logic [NRDY-1:0] rdy,
    input  logic [RSW-1:0]  sel_a,
    input  logic [RSW-1:0]  sel_b,
    input  cond_op_e        op,
    output logic            hit
);
    localparam int EXTW = 1 << RSW;
    logic [EXTW-1:0] rdy_ext;
    logic a, b;

    assign rdy_ext = {{(EXTW-NRDY){1'b0}}, rdy};
    assign a = rdy_ext[sel_a];
    assign b = rdy_ext[sel_b];

    always_comb begin
        unique case (op)
            OP_A:    hit = a;
            OP_AND:  hit = a & b;
            OP_OR:   hit = a | b;
            OP_XOR:  hit = a ^ b;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/wm_txn_count.sv
module wm_txn_count #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          at_one
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (dec)
            cnt <= cnt - 1'b1;
    end

    assign at_one = (cnt == {{(CW-1){1'b0}}, 1'b1});
endmodule

// File: rtl/wm_engine.sv
module wm_engine import wm_pkg::*; #(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [VIW-1:0]    cfg_idx,
    input  logic [VEC_W-1:0]  cfg_word,
    input  logic              start,
    input  logic              start_dir,
    input  logic [CNT_W-1:0]  count_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [NRDY-1:0]   rdy_in,
    input  logic              fifo_full,
    input  logic              fifo_empty,
    output logic [NCTL-1:0]   ctl_out,
    output logic [ADDR_W-1:0] addr_out,
    output logic              fifo_rd,
    output logic              fifo_wr,
    output logic              busy,
    output logic              done
);
    wm_state_e         st, st_nx;
    logic [VIW-1:0]    pc, pc_nx;
    logic              dir_q;
    logic [ADDR_W-1:0] addr_q;
    wvec_t             cur;
    logic              cond, stall, take, fin_txn, last_txn;
    logic              idle_start;

    assign idle_start = (st == S_IDLE) && start;

    wm_vec_table #(.NV(NVEC)) u_tab (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we && (st == S_IDLE)),
        .wr_idx  (cfg_idx),
        .wr_data (wvec_t'(cfg_word)),
        .rd_idx  (pc),
        .rd_data (cur)
    );

    wm_cond u_cond (
        .rdy   (rdy_in),
        .sel_a (cur.sel_a),
        .sel_b (cur.sel_b),
        .op    (cur.op),
        .hit   (cond)
    );

    assign stall   = cur.adv_fifo && (dir_q ? fifo_full : fifo_empty);
    assign take    = (st == S_RUN) && !stall && cond;
    assign fin_txn = take && cur.last;

    wm_txn_count #(.CW(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (idle_start),
        .load_val (count_in),
        .dec      (fin_txn),
        .at_one   (last_txn)
    );

    // next state and next vector index
    always_comb begin
        st_nx = st;
        pc_nx = pc;
        unique case (st)
            S_IDLE: begin
                if (start) begin
                    pc_nx = '0;
                    st_nx = (count_in == '0) ? S_FINISH : S_RUN;
                end
            end
            S_RUN: begin
                if (!stall) begin
                    if (cond) begin
                        if (cur.last) begin
                            pc_nx = '0;
                            if (last_txn)
                                st_nx = S_FINISH;
                        end else begin
                            pc_nx = cur.nxt_t;
                        end
                    end else begin
                        pc_nx = cur.nxt_f;
                    end
                end
            end
            S_FINISH: st_nx = S_IDLE;
            default:  st_nx = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= S_IDLE;
            pc     <= '0;
            dir_q  <= 1'b0;
            addr_q <= '0;
        end else begin
            st <= st_nx;
            pc <= pc_nx;
            if (idle_start) begin
                dir_q  <= start_dir;
                addr_q <= addr_in;
            end else if (take && cur.inc_addr) begin
                addr_q <= addr_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        ctl_out = '0;
        busy    = 1'b0;
        done    = 1'b0;
        fifo_rd = 1'b0;
        fifo_wr = 1'b0;
        unique case (st)
            S_IDLE: ;
            S_RUN: begin
                busy    = 1'b1;
                ctl_out = cur.ctl;
                fifo_rd = take && cur.adv_fifo && !dir_q;
                fifo_wr = take && cur.adv_fifo &&  dir_q;
            end
            S_FINISH: done = 1'b1;
            default: ;
        endcase
    end

    assign addr_out = addr_q;
endmodule

// File: rtl/wm_check.sv
module wm_check import wm_pkg::*; #(
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              fifo_full,
    input logic              fifo_empty,
    input logic [NCTL-1:0]   ctl_out,
    input logic [ADDR_W-1:0] addr_out,
    input logic              fifo_rd,
    input logic              fifo_wr,
    input logic              busy,
    input logic              done
);
    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_rd && fifo_wr));

    p_strobe_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_rd || fifo_wr) |-> busy);

    p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> !fifo_empty);

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> !fifo_full);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_idle_ctl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ctl_out == '0));

    p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(addr_out));
endmodule

bind wm_engine wm_check #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .ctl_out    (ctl_out),
    .addr_out   (addr_out),
    .fifo_rd    (fifo_rd),
    .fifo_wr    (fifo_wr),
    .busy       (busy),
    .done       (done)
);

// File: tb/sim_wm_engine.sv
`timescale 1ns/1ps
module sim_wm_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [22:0] cfg_word = '0;
    logic        start = 1'b0;
    logic        start_dir = 1'b0;
    logic [31:0] count_in = '0;
    logic [8:0]  addr_in = '0;
    logic [5:0]  rdy_in = '0;
    logic        fifo_full = 1'b0;
    logic        fifo_empty = 1'b0;
    logic [5:0]  ctl_out;
    logic [8:0]  addr_out;
    logic        fifo_rd, fifo_wr, busy, done;

    int nchk = 0;
    int nfail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    wm_engine u0 (.*);

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [22:0] mkv(input logic [5:0] ctl, input logic [2:0] sa,
        input logic [2:0] sb, input logic [1:0] op, input logic [2:0] nt,
        input logic [2:0] nf, input logic last, input logic adv, input logic inc);
        return {inc, adv, last, nf, nt, op, sb, sa, ctl};
    endfunction

    function automatic bit cond_f(input logic [1:0] op, input logic [2:0] sa,
                                  input logic [2:0] sb, input logic [5:0] r);
        logic [7:0] e;
        e = {2'b00, r};
        case (op)
            2'd0: return e[sa];
            2'd1: return e[sa] & e[sb];
            2'd2: return e[sa] | e[sb];
            default: return e[sa] ^ e[sb];
        endcase
    endfunction

    task automatic wr_vec(input logic [2:0] idx, input logic [22:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = idx; cfg_word = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // leaves the bench at the negedge after the start edge
    task automatic go(input int cnt, input int a, input bit d);
        @(negedge clk);
        start = 1'b1; count_in = cnt; addr_in = a[8:0]; start_dir = d;
        @(negedge clk);
        start = 1'b0;
        #1;
    endtask

    task automatic step;
        @(negedge clk);
        #1;
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h1234);
        repeat (3) @(posedge clk);
        #1;
        check(busy == 0 && done == 0 && ctl_out == 0 && addr_out == 0 &&
              fifo_rd == 0 && fifo_wr == 0, "R1", "reset outputs",
              {busy, done, fifo_rd, fifo_wr, ctl_out}, 0);
        rst_n = 1'b1;

        // directed branching table
        wr_vec(0, mkv(6'h01, 0, 0, 2'd0, 1, 0, 0, 0, 0));
        wr_vec(1, mkv(6'h02, 1, 2, 2'd1, 3, 2, 0, 0, 1));
        wr_vec(2, mkv(6'h04, 5, 5, 2'd0, 3, 3, 0, 0, 0));
        wr_vec(3, mkv(6'h08, 3, 4, 2'd3, 0, 3, 1, 1, 0));

        rdy_in = 6'b000000;
        go(1, 5, 0);
        check(busy == 1 && ctl_out == 6'h01, "R3", "run at entry 0", ctl_out, 1);
        check(addr_out == 5, "R3", "address latched", addr_out, 5);
        step();
        check(ctl_out == 6'h01, "R6", "wait on false path", ctl_out, 1);
        // start and table write during the run must be ignored
        start = 1'b1; count_in = 5; cfg_we = 1'b1; cfg_idx = 0;
        cfg_word = mkv(6'h30, 0, 0, 2'd0, 1, 0, 0, 0, 0);
        step();
        start = 1'b0; cfg_we = 1'b0;
        check(ctl_out == 6'h01, "R11", "still waiting", ctl_out, 1);
        rdy_in = 6'b000011;
        step();
        check(ctl_out == 6'h02, "R6", "true successor", ctl_out, 2);
        step();
        check(ctl_out == 6'h04, "R5", "AND false goes to false successor", ctl_out, 4);
        step();
        check(ctl_out == 6'h08, "R4", "ctl follows vector", ctl_out, 8);
        check(addr_out == 5, "R6", "no increment on false path", addr_out, 5);
        rdy_in = 6'b011000;
        #1;
        check(fifo_rd == 0, "R6", "no strobe while condition false", fifo_rd, 0);
        step();
        check(ctl_out == 6'h08, "R5", "XOR false holds", ctl_out, 8);
        rdy_in = 6'b001000;
        #1;
        check(fifo_rd == 1 && fifo_wr == 0, "R7", "pop strobe direction 0", fifo_rd, 1);
        step();
        check(done == 1 && busy == 0 && ctl_out == 0, "R9", "done after last transaction",
              done, 1);
        step();
        check(done == 0 && busy == 0, "R11", "done once, count 5 not taken", done, 0);

        // second run: write ignored, address wrap, direction 1
        rdy_in = 6'b001111;
        go(2, 9'h1FF, 1);
        check(ctl_out == 6'h01, "R2", "busy write left entry 0", ctl_out, 1);
        step();
        check(ctl_out == 6'h02, "R6", "AND true", ctl_out, 2);
        step();
        check(ctl_out == 6'h08 && addr_out == 0, "R7", "address wrap", addr_out, 0);
        check(fifo_wr == 1 && fifo_rd == 0, "R7", "push strobe direction 1", fifo_wr, 1);
        step();
        check(ctl_out == 6'h01 && busy == 1, "R9", "restart at entry 0", ctl_out, 1);
        step(); step();
        check(addr_out == 1, "R7", "second increment", addr_out, 1);
        step();
        check(done == 1, "R9", "done after two transactions", done, 1);

        // zero count
        go(0, 3, 0);
        check(done == 1 && busy == 0 && ctl_out == 0, "R10", "zero count done", done, 1);
        step();
        check(done == 0 && addr_out == 3, "R10", "back to idle", done, 0);

        // operator sweep with random inputs
        wr_vec(1, mkv(6'h01, 0, 0, 2'd0, 0, 1, 1, 0, 0));
        wr_vec(2, mkv(6'h02, 0, 0, 2'd0, 0, 2, 1, 0, 0));
        for (int i = 0; i < 24; i++) begin
            logic [1:0] op;
            logic [2:0] sa, sb;
            logic [5:0] r;
            bit exp;
            op = 2'($urandom % 4); sa = 3'($urandom % 8); sb = 3'($urandom % 8);
            r = 6'($urandom);
            exp = cond_f(op, sa, sb, r);
            wr_vec(0, mkv(6'h3F, sa, sb, op, 1, 2, 0, 0, 0));
            rdy_in = r;
            go(1, 0, 0);
            check(ctl_out == 6'h3F, "R2", "written vector active", ctl_out, 63);
            step();
            check(ctl_out == (exp ? 6'h01 : 6'h02), "R5", "condition branch",
                  ctl_out, exp ? 1 : 2);
            rdy_in = 6'h3F;
            step();
            check(done == 1, "R9", "done after sweep run", done, 1);
            step();
        end

        // random throttling
        wr_vec(0, mkv(6'h11, 0, 0, 2'd0, 1, 0, 0, 1, 1));
        wr_vec(1, mkv(6'h22, 0, 0, 2'd0, 0, 1, 1, 0, 1));
        rdy_in = 6'h3F;
        for (int k = 0; k < 6; k++) begin
            int cnt, a0, strobes, bad, guard;
            bit d;
            cnt = 1 + int'($urandom % 20);
            a0 = int'($urandom % 512);
            d = 1'($urandom % 2);
            strobes = 0; bad = 0; guard = 0;
            fifo_full = 1'b0; fifo_empty = 1'b0;
            @(negedge clk);
            start = 1'b1; count_in = cnt; addr_in = a0[8:0]; start_dir = d;
            @(negedge clk);
            start = 1'b0;
            while (!done && guard < 2000) begin
                fifo_full = 1'($urandom % 2);
                fifo_empty = 1'($urandom % 2);
                #1;
                if (fifo_rd || fifo_wr) strobes++;
                if ((d ? fifo_rd : fifo_wr) ||
                    (fifo_rd && fifo_empty) || (fifo_wr && fifo_full)) bad++;
                @(negedge clk);
                guard++;
            end
            #1;
            check(bad == 0, "R8", "strobe against blocking flag", bad, 0);
            check(strobes == cnt, "R9", "strobes per count", strobes, cnt);
            check(addr_out == 9'((a0 + 2 * cnt) % 512), "R7", "final address",
                  addr_out, (a0 + 2 * cnt) % 512);
            fifo_full = 1'b0; fifo_empty = 1'b0;
            step();
        end

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule